// File: doc/BRIEF.md
# Bidirectional Occupancy Counter

This block tracks how many people are inside a room. Two sensor lines arrive from outside the chip with no relation to its clock. One line pulses when a person enters and the other pulses when a person leaves. Neither line is ever used as a clock. Both are sampled in a single fast system clock domain.

Each line passes through a flip-flop synchronizer and then a hold-time glitch filter. A rising-edge detector follows, and it produces a one-cycle step request. A saturating up/down register combines the two requests into the occupancy value. An enable input can pause counting without stalling the front end.

The integrator sets the maximum occupancy with `CNT_MAX`, the filter hold time with `DB_HOLD` and the synchronizer depth with `SYNC_STAGES`. The output width is derived from `CNT_MAX`.

Top module: `occ_counter`

## Requirements
- R1: An active-high `rst` clears `count` to 0 asynchronously, without waiting for a clock edge, and holds it at 0 while asserted.
- R2: A clean rising edge on `entry_raw`, held at least `DB_HOLD` clocks, raises `count` by exactly one within `SYNC_STAGES + DB_HOLD + 2` clocks. Holding the line high afterwards adds nothing more.
- R3: A clean rising edge on `exit_raw`, held at least `DB_HOLD` clocks, lowers `count` by exactly one.
- R4: A pulse on either line lasting less than one clock period is filtered out and leaves `count` unchanged.
- R5: A rising edge that bounces several times with sub-clock pulses before settling high counts as one event.
- R6: When entry and exit edges produce their step requests in the same clock cycle, `count` does not change.
- R7: `count` never exceeds `CNT_MAX` (default 9). An entry event at `CNT_MAX` is ignored and does not wrap.
- R8: An exit event while `count` is 0 is ignored, and `count` stays 0.
- R9: While `en` is low, step requests are discarded. An edge that arrived while `en` was low does not change `count` after `en` returns high.
- R10: `count` changes only in the cycle after a step request, and by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| en | input | 1 | Counting enable; the front end keeps running while low |
| entry_raw | input | 1 | Unsynchronized entry sensor line |
| exit_raw | input | 1 | Unsynchronized exit sensor line |
| count | output | CNT_W | Current occupancy, 0 to CNT_MAX; CNT_W is derived from CNT_MAX |

## Verification
The checker assumes three things about the step requests. Each request is a single-cycle pulse. Requests can coincide only when both raw lines change together. `en` is a level that the checker samples only at clock edges.

The bench stays inside these assumptions. It changes the raw lines only between clock edges, at random offsets. It holds every settled level for well over `DB_HOLD` clocks. It keeps bounce and glitch pulses shorter than one clock period. It lets each event fully drain through the synchronizer, the filter and the edge detector before it compares the result against its saturating reference model.

// File: rtl/occ_pkg.sv
// Shared types and helpers for the occupancy counter.
package occ_pkg;

    // Number of sensor channels handled by the front end.
    localparam int NUM_TRIG = 2;

    // Channel index of each sensor line in the front-end arrays.
    typedef enum logic [0:0] {
        TRIG_ENTRY = 1'b0,
        TRIG_EXIT  = 1'b1
    } trig_id_e;

    // Step requests handed from the edge detectors to the counter.
    typedef struct packed {
        logic up;
        logic down;
    } step_req_t;

    // Action the counter takes in a given cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Bits needed to hold the values 0..max_val.
    function automatic int bits_for(input int max_val);
        if (max_val < 2) begin
            return 1;
        end
        return $clog2(max_val + 1);
    endfunction

    // Chooses the action from the requests, the enable and the bounds.
    function automatic step_e decide_step(
        input step_req_t req,
        input logic      enable,
        input logic      at_top,
        input logic      at_floor
    );
        step_e act;
        act = STEP_HOLD;
        if (enable) begin
            if (req.up && !req.down) begin
                act = at_top ? STEP_HOLD : STEP_UP;
            end else if (req.down && !req.up) begin
                act = at_floor ? STEP_HOLD : STEP_DOWN;
            end
        end
        return act;
    endfunction

endpackage

// File: rtl/occ_sync.sv
// Multi-stage flip-flop synchronizer for one asynchronous line.
module occ_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/occ_debounce.sv
// Level filter: a new level is accepted only after HOLD identical samples.
module occ_debounce #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);

    localparam int RW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
    localparam logic [RW-1:0] LAST = RW'(HOLD - 1);

    logic [RW-1:0] run;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            level <= 1'b0;
            run   <= '0;
        end else if (din == level) begin
            run <= '0;
        end else if (run == LAST) begin
            level <= din;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/occ_edge.sv
// Rising-edge detector producing a one-cycle pulse.
module occ_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);

    logic prev;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            prev <= level;
        end
    end

    assign rise = level & ~prev;

endmodule

// File: rtl/occ_updown.sv
// Saturating up/down occupancy register.
module occ_updown
    import occ_pkg::*;
#(
    parameter int CNT_MAX = 9,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  step_req_t        req,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    step_e act;

    always_comb begin
        act = decide_step(req, en, (count == TOP), (count == '0));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (act)
                STEP_UP:   count <= count + 1'b1;
                STEP_DOWN: count <= count - 1'b1;
                default:   count <= count;
            endcase
        end
    end

endmodule

// File: rtl/occ_counter.sv
// Occupancy counter top: per-line front end feeding a saturating counter.
module occ_counter
    import occ_pkg::*;
#(
    parameter int CNT_MAX     = 9,
    parameter int DB_HOLD     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = bits_for(CNT_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             entry_raw,
    input  logic             exit_raw,
    output logic [CNT_W-1:0] count
);

    logic [NUM_TRIG-1:0] raw_vec;
    logic [NUM_TRIG-1:0] sync_vec;
    logic [NUM_TRIG-1:0] clean_vec;
    logic [NUM_TRIG-1:0] rise_vec;
    logic                up_stb;
    logic                dn_stb;
    step_req_t           req;

    assign raw_vec[TRIG_ENTRY] = entry_raw;
    assign raw_vec[TRIG_EXIT]  = exit_raw;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_front
        occ_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .d_async (raw_vec[i]),
            .q_sync  (sync_vec[i])
        );

        occ_debounce #(.HOLD(DB_HOLD)) u_db (
            .clk   (clk),
            .rst   (rst),
            .din   (sync_vec[i]),
            .level (clean_vec[i])
        );

        occ_edge u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (clean_vec[i]),
            .rise  (rise_vec[i])
        );
    end

    assign up_stb   = rise_vec[TRIG_ENTRY];
    assign dn_stb   = rise_vec[TRIG_EXIT];
    assign req.up   = up_stb;
    assign req.down = dn_stb;

    occ_updown #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .req   (req),
        .count (count)
    );

endmodule

// File: rtl/occ_counter_chk.sv
// Property checker attached to the occupancy counter.
module occ_counter_chk #(
    parameter int CNT_MAX = 9,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             up_stb,
    input logic             dn_stb,
    input logic [CNT_W-1:0] count
);

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= CNT_MAX);

    // R7
    ceiling_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(count) == CNT_MAX && up_stb && !dn_stb) |=> $stable(count));

    // R8
    floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && dn_stb && !up_stb) |=> (count == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && up_stb && !dn_stb && int'(count) < CNT_MAX)
        |=> (count == CNT_W'($past(count) + 1'b1)));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dn_stb && !up_stb && count != '0)
        |=> (count == CNT_W'($past(count) - 1'b1)));

    // R6
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_stb && dn_stb) |=> $stable(count));

    // R9
    en_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_stb && !dn_stb) |=> $stable(count));

    // R5
    up_single_chk: assert property (@(posedge clk) disable iff (rst)
        up_stb |=> !up_stb);

    // R5
    down_single_chk: assert property (@(posedge clk) disable iff (rst)
        dn_stb |=> !dn_stb);

endmodule

bind occ_counter occ_counter_chk #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .up_stb (up_stb),
    .dn_stb (dn_stb),
    .count  (count)
);

// File: tb/sim_occ_counter.sv
module sim_occ_counter;
    import occ_pkg::*;

    localparam int CNT_MAX = 9;
    localparam int DB_HOLD = 4;
    localparam int W       = bits_for(CNT_MAX);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         entry_raw = 1'b0;
    logic         exit_raw = 1'b0;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    occ_counter #(.CNT_MAX(CNT_MAX), .DB_HOLD(DB_HOLD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .entry_raw (entry_raw),
        .exit_raw  (exit_raw),
        .count     (count)
    );

    function automatic int model_step(int cur, bit up, bit dn, bit enb);
        if (!enb || (up && dn)) return cur;
        if (up) return (cur < CNT_MAX) ? cur + 1 : cur;
        if (dn) return (cur > 0) ? cur - 1 : cur;
        return cur;
    endfunction

    task automatic check(string req, int exp);
        checks++;
        if ($isunknown(count) || int'(count) != exp) begin
            errors++;
            $display("FAIL %s: count=%0d expected %0d", req, count, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit up, bit dn, bit val);
        if (up) entry_raw = val;
        if (dn) exit_raw = val;
    endtask

    // One event: rise (optionally bouncing), hold, fall (optionally bouncing).
    task automatic pulse(bit up, bit dn, bit bounce);
        #($urandom_range(1, 4));
        if (bounce) begin
            for (int k = 0; k < 3; k++) begin
                drive(up, dn, 1'b1); #7;
                drive(up, dn, 1'b0); #6;
            end
        end
        drive(up, dn, 1'b1);
        repeat (DB_HOLD + 8) @(posedge clk);
        #3;
        if (bounce) begin
            for (int k = 0; k < 3; k++) begin
                drive(up, dn, 1'b0); #7;
                drive(up, dn, 1'b1); #6;
            end
        end
        drive(up, dn, 1'b0);
        settle(DB_HOLD + 12);
    endtask

    task automatic glitch(bit up, bit dn);
        #($urandom_range(1, 3));
        drive(up, dn, 1'b1);
        #6;
        drive(up, dn, 1'b0);
        settle(DB_HOLD + 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, count=%0d expected %0d", count, model);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        settle(3);
        check("R1 reset value", 0);
        rst = 1'b0;
        en  = 1'b1;
        settle(2);

        pulse(1, 0, 0); model = 1;  check("R2 clean entry", model);
        pulse(0, 1, 0); model = 0;  check("R3 clean exit", model);
        pulse(0, 1, 0);             check("R8 exit at zero", 0);
        glitch(1, 0);               check("R4 entry glitch", 0);
        pulse(1, 0, 1); model = 1;  check("R5 bouncing entry", model);
        glitch(0, 1);               check("R4 exit glitch", model);
        pulse(1, 1, 0);             check("R6 coincident events", model);
        pulse(0, 1, 1); model = 0;  check("R5 bouncing exit", model);

        for (int i = 0; i < CNT_MAX + 3; i++) begin
            pulse(1, 0, 0);
            model = model_step(model, 1, 0, 1);
            check("R7 climb to ceiling", model);
        end
        check("R7 saturated at max", CNT_MAX);

        // Enable low: edge arrives and is held while disabled.
        en = 1'b0;
        pulse(0, 1, 0);
        check("R9 exit while disabled", model);
        #2 entry_raw = 1'b1;
        en = 1'b0;
        settle(DB_HOLD + 12);
        en = 1'b1;
        settle(DB_HOLD + 12);
        check("R9 no stale edge after enable", model);
        #2 entry_raw = 1'b0;
        settle(DB_HOLD + 12);
        en = 1'b1;
        pulse(0, 1, 0); model = model_step(model, 0, 1, 1);
        check("R9 counting resumes", model);

        // Asynchronous reset mid-run, checked before the next clock edge.
        #2 rst = 1'b1;
        #1 check("R1 async clear", 0);
        model = 0;
        settle(2);
        #1 rst = 1'b0;
        settle(2);

        for (int i = 0; i < 160; i++) begin
            int kind;
            kind = int'($urandom_range(0, 5));
            case (kind)
                0: begin pulse(1, 0, 0); model = model_step(model, 1, 0, 1); end
                1: begin pulse(0, 1, 0); model = model_step(model, 0, 1, 1); end
                2: begin pulse(1, 1, 0); model = model_step(model, 1, 1, 1); end
                3: begin glitch($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1); end
                4: begin pulse(1, 0, 1); model = model_step(model, 1, 0, 1); end
                default: begin pulse(0, 1, 1); model = model_step(model, 0, 1, 1); end
            endcase
            check("R10 random event", model);
        end

        finish_run();
    end

endmodule